// File: doc/BRIEF.md
# Status Register and Alarm Matcher

This block keeps the volatile status byte of a real-time clock and decides when either of its two alarms fires. Once per second, on a tick from the timekeeping counter, it compares the current calendar fields against two alarm settings. Every alarm field carries its own enable bit. When all enabled fields of an alarm match, that alarm's flag is set and stays set until software reads the status byte.

The status byte also carries two write-enable latches, which guard the rest of the clock's register space. They can only be set in a fixed order and only by exact byte values. It also passes through three flags owned by hardware: battery operation, oscillator failure and total power loss.

A status read is signalled by two strobes, one at the start of the read and one at its last data bit. The read clears only the alarm flags that were already set when the read began. An alarm that fires while the read is in flight survives the read.

Top module: `rtc_stat_alarm`

## Requirements
- R1: `status_byte` carries, from bit 7 down to bit 0: `hw_bat`, alarm 1 flag, alarm 0 flag, `hw_oscf`, constant 0, register write-enable latch, write-enable latch, `hw_rtcf`. With `hw_rtcf`=1 and the other hardware inputs at 0, it reads 01h after reset.
- R2: A status write never changes bits 7, 4 and 0 or the alarm flags. Those bits follow the hardware inputs only.
- R3: Each alarm setting has six bytes; byte k sits at bits 8k+7:8k. The fields are k=0 seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 day of week. Bit 7 of a byte enables that field, and bits 6:0 are compared with bits 6:0 of the same byte of `cur_time`. In a cycle with `tick_1s`=1 where every enabled field matches, the alarm's flag is set and is visible the next cycle. A flag stays set over later ticks that do not match.
- R4: A field whose enable bit is 0 takes no part in the match, whatever its value.
- R5: Without `tick_1s`, a matching time never sets a flag.
- R6: An alarm with no enabled field never sets its flag.
- R7: `rd_start` records which flags are set. `rd_done` clears exactly those flags, and the result is visible the next cycle.
- R8: A flag that becomes set after `rd_start`, or in the `rd_done` cycle, is still set after the read.
- R9: Both latches are 0 after reset. A write of 02h sets the write-enable latch and clears the register write-enable latch. A write of 00h clears both latches.
- R10: A write of 06h sets the register write-enable latch only while the write-enable latch is already 1. Otherwise it changes nothing. The register latch is never 1 while the write-enable latch is 0.
- R11: A write of any other byte value, and any cycle without `st_wr`, leaves both latches unchanged.
- R12: `wel_o` and `rwel_o` equal status bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-cycle pulse once per second |
| cur_time | input | ALM_FIELDS*8 | Current time, one byte per field |
| alm0_cfg | input | ALM_FIELDS*8 | Alarm 0 setting, enable in bit 7 of each byte |
| alm1_cfg | input | ALM_FIELDS*8 | Alarm 1 setting, enable in bit 7 of each byte |
| st_wr | input | 1 | Status byte write strobe |
| st_wdata | input | 8 | Status byte write data |
| rd_start | input | 1 | A status read begins |
| rd_done | input | 1 | Last data bit of a status read |
| hw_bat | input | 1 | Running from battery |
| hw_oscf | input | 1 | Oscillator failure |
| hw_rtcf | input | 1 | Total power loss seen |
| status_byte | output | 8 | Status byte |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register write-enable latch |

## Verification
The bench builds the block with its defaults, ALM_FIELDS=6 and CMP_BITS=7. These values put all six fields, including day of week, and all seven compared bits within reach of the directed stimulus. The hour byte of the time carries bit 7 set, which shows that this bit is kept out of the comparison. The flag sequences exercised are a match, a sticky hold, a clear on read, and an alarm raised between the read strobes. The latch tests cover every ordering of 00h, 02h and 06h, plus stray byte values.

// File: rtl/stalm_pkg.sv
package stalm_pkg;
  localparam int ALARMS = 2;

  localparam logic [7:0] WR_CLEAR = 8'h00;
  localparam logic [7:0] WR_WEL   = 8'h02;
  localparam logic [7:0] WR_BOTH  = 8'h06;

  typedef struct packed {
    logic rwel;
    logic wel;
  } wlatch_t;

  // Next state of the enable latches for one status write.
  function automatic wlatch_t wlatch_next(wlatch_t cur, logic [7:0] d);
    wlatch_t n;
    n = cur;
    case (d)
      WR_CLEAR: n = '0;
      WR_WEL: begin
        n.wel  = 1'b1;
        n.rwel = 1'b0;
      end
      WR_BOTH: if (cur.wel) n.rwel = 1'b1;
      default: n = cur;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/stalm_match.sv
module stalm_match #(
  parameter int ALM_FIELDS = 6,
  parameter int CMP_BITS   = 7
) (
  input  logic                    tick,
  input  logic [ALM_FIELDS*8-1:0] cfg,
  input  logic [ALM_FIELDS*8-1:0] now,
  output logic                    hit,
  output logic                    any_en
);
  logic [ALM_FIELDS-1:0] fld_en;
  logic [ALM_FIELDS-1:0] fld_ok;

  function automatic logic field_ok(logic [7:0] c, logic [7:0] t);
    return !c[7] || (c[CMP_BITS-1:0] == t[CMP_BITS-1:0]);
  endfunction

  for (genvar f = 0; f < ALM_FIELDS; f++) begin : g_fld
    assign fld_en[f] = cfg[8*f+7];
    assign fld_ok[f] = field_ok(cfg[8*f +: 8], now[8*f +: 8]);
  end

  assign any_en = |fld_en;
  assign hit    = tick && any_en && (&fld_ok);
endmodule

// File: rtl/stalm_flags.sv
module stalm_flags
  import stalm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ALARMS-1:0] hit,
  input  logic              rd_start,
  input  logic              rd_done,
  output logic [ALARMS-1:0] flags
);
  logic [ALARMS-1:0] snap;
  logic [ALARMS-1:0] clr_mask;

  assign clr_mask = rd_done ? snap : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      if (rd_start)     snap <= flags;
      else if (rd_done) snap <= '0;
      flags <= (flags & ~clr_mask) | hit;
    end
  end

  for (genvar i = 0; i < ALARMS; i++) begin : g_chk
    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flags[i]); // R3
    AST_READ_CLEARS_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && snap[i] && !hit[i]) |=> !flags[i]); // R7
    AST_LATE_FLAG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && flags[i] && !snap[i]) |=> flags[i]); // R8
  end
endmodule

// File: rtl/stalm_wel.sv
module stalm_wel
  import stalm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_wr,
  input  logic [7:0] st_wdata,
  output logic       wel,
  output logic       rwel
);
  wlatch_t lat;

  always_ff @(posedge clk) begin
    if (!rst_n)     lat <= '0;
    else if (st_wr) lat <= wlatch_next(lat, st_wdata);
  end

  assign wel  = lat.wel;
  assign rwel = lat.rwel;

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && st_wdata == WR_CLEAR) |=> (!wel && !rwel)); // R9
  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    rwel |-> wel); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> ($stable(wel) && $stable(rwel))); // R11
endmodule

// File: rtl/rtc_stat_alarm.sv
module rtc_stat_alarm
  import stalm_pkg::*;
#(
  parameter int ALM_FIELDS = 6,
  parameter int CMP_BITS   = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_1s,
  input  logic [ALM_FIELDS*8-1:0] cur_time,
  input  logic [ALM_FIELDS*8-1:0] alm0_cfg,
  input  logic [ALM_FIELDS*8-1:0] alm1_cfg,
  input  logic                    st_wr,
  input  logic [7:0]              st_wdata,
  input  logic                    rd_start,
  input  logic                    rd_done,
  input  logic                    hw_bat,
  input  logic                    hw_oscf,
  input  logic                    hw_rtcf,
  output logic [7:0]              status_byte,
  output logic                    wel_o,
  output logic                    rwel_o
);
  localparam int CFG_W = ALM_FIELDS * 8;

  logic [ALARMS-1:0][CFG_W-1:0] cfg_arr;
  logic [ALARMS-1:0]            alm_hit;
  logic [ALARMS-1:0]            alm_any_en;
  logic [ALARMS-1:0]            alm_flag;

  assign cfg_arr[0] = alm0_cfg;
  assign cfg_arr[1] = alm1_cfg;

  for (genvar g = 0; g < ALARMS; g++) begin : g_alm
    stalm_match #(.ALM_FIELDS(ALM_FIELDS), .CMP_BITS(CMP_BITS)) u_match (
      .tick   (tick_1s),
      .cfg    (cfg_arr[g]),
      .now    (cur_time),
      .hit    (alm_hit[g]),
      .any_en (alm_any_en[g])
    );

    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alm_flag[g]) |-> $past(tick_1s)); // R5
    AST_NO_ENABLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (!alm_any_en[g] && !alm_flag[g]) |=> !alm_flag[g]); // R6
  end

  stalm_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (alm_hit),
    .rd_start (rd_start),
    .rd_done  (rd_done),
    .flags    (alm_flag)
  );

  stalm_wel u_wel (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_wr    (st_wr),
    .st_wdata (st_wdata),
    .wel      (wel_o),
    .rwel     (rwel_o)
  );

  assign status_byte = {hw_bat, alm_flag[1], alm_flag[0], hw_oscf,
                        1'b0, rwel_o, wel_o, hw_rtcf};

  AST_WRITE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !tick_1s && !rd_done) |=> $stable(alm_flag)); // R2
endmodule

// File: tb/sim_rtc_stat_alarm.sv
module sim_rtc_stat_alarm;
  localparam int NF = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_1s = 1'b0;
  logic [NF*8-1:0] cur_time = '0;
  logic [NF*8-1:0] alm0_cfg = '0;
  logic [NF*8-1:0] alm1_cfg = '0;
  logic          st_wr = 1'b0;
  logic [7:0]    st_wdata = '0;
  logic          rd_start = 1'b0;
  logic          rd_done = 1'b0;
  logic          hw_bat = 1'b0;
  logic          hw_oscf = 1'b0;
  logic          hw_rtcf = 1'b1;
  logic [7:0]    status_byte;
  logic          wel_o;
  logic          rwel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [1:0] m_al = '0;
  logic [1:0] m_snap = '0;
  logic       m_wel = 0;
  logic       m_rwel = 0;

  always #4 clk = ~clk;

  rtc_stat_alarm u0 (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .cur_time(cur_time),
    .alm0_cfg(alm0_cfg), .alm1_cfg(alm1_cfg), .st_wr(st_wr), .st_wdata(st_wdata),
    .rd_start(rd_start), .rd_done(rd_done), .hw_bat(hw_bat), .hw_oscf(hw_oscf),
    .hw_rtcf(hw_rtcf), .status_byte(status_byte), .wel_o(wel_o), .rwel_o(rwel_o)
  );

  // Reference match: count the enabled fields and the matching enabled fields.
  function automatic logic m_hit(logic [NF*8-1:0] c, logic [NF*8-1:0] t);
    int en_cnt = 0;
    int ok_cnt = 0;
    for (int k = 0; k < NF; k++) begin
      if (c[8*k+7]) begin
        en_cnt++;
        if ((c[8*k +: 8] & 8'h7f) == (t[8*k +: 8] & 8'h7f)) ok_cnt++;
      end
    end
    return (en_cnt > 0) && (en_cnt == ok_cnt);
  endfunction

  function automatic logic [7:0] m_status();
    return {hw_bat, m_al[1], m_al[0], hw_oscf, 1'b0, m_rwel, m_wel, hw_rtcf};
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, status_byte, m_status());
    chk({req, " R12"}, {6'd0, rwel_o, wel_o}, {6'd0, status_byte[2], status_byte[1]});
  endtask

  task automatic do_tick();
    tick_1s = 1'b1;
    m_al[0] = m_al[0] | m_hit(alm0_cfg, cur_time);
    m_al[1] = m_al[1] | m_hit(alm1_cfg, cur_time);
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic st_write(logic [7:0] d);
    st_wr = 1'b1;
    st_wdata = d;
    if (d == 8'h00) begin
      m_wel = 0;
      m_rwel = 0;
    end else if (d == 8'h02) begin
      m_wel = 1;
      m_rwel = 0;
    end else if (d == 8'h06 && m_wel) begin
      m_rwel = 1;
    end
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  task automatic rd_begin();
    rd_start = 1'b1;
    m_snap = m_al;
    @(negedge clk);
    rd_start = 1'b0;
  endtask

  task automatic rd_end();
    rd_done = 1'b1;
    m_al = m_al & ~m_snap;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  function automatic logic [NF*8-1:0] mk(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                                         logic [7:0] dt, logic [7:0] mo, logic [7:0] dw);
    return {dw, mo, dt, h, mi, s};
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset value", status_byte, 8'h01);
    chk("R9 latches after reset", {6'd0, rwel_o, wel_o}, 8'h00);
  endtask

  task automatic t_hw_bits();
    hw_bat = 1; hw_oscf = 1; hw_rtcf = 0;
    #1;
    chk("R1 hardware bits", status_byte, 8'h90);
    st_write(8'hff);
    chk("R2 write of FFh leaves hw bits", status_byte, 8'h90);
    hw_bat = 0; hw_oscf = 0; hw_rtcf = 1;
    #1;
    chk_all("R11 FFh no latch change");
  endtask

  task automatic t_alarm_basic();
    cur_time = mk(8'h58, 8'h59, 8'h80 | 8'h23, 8'h31, 8'h12, 8'h03);
    alm0_cfg = mk(8'hd8, 8'hd9, 8'ha3, 8'hb1, 8'h92, 8'h83);
    alm1_cfg = mk(8'h57, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    repeat (5) @(negedge clk);
    chk("R5 no tick no flag", status_byte, 8'h01);
    do_tick();
    chk("R3 all fields match sets alarm 0", status_byte, 8'h21);
    chk_all("R3 model");
  endtask

  task automatic t_read_clear();
    rd_begin();
    @(negedge clk);
    chk("R7 flag held until rd_done", status_byte, 8'h21);
    rd_end();
    chk("R7 read clears flag", status_byte, 8'h01);
  endtask

  task automatic t_disabled_field();
    alm1_cfg = mk(8'hd8, 8'h05, 8'h11, 8'h00, 8'h00, 8'h00);
    do_tick();
    chk("R4 disabled fields ignored", status_byte, 8'h61);
    cur_time = mk(8'h10, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    do_tick();
    chk("R3 flags sticky on non-match", status_byte, 8'h61);
    rd_begin();
    rd_end();
    chk("R7 both cleared", status_byte, 8'h01);
  endtask

  task automatic t_read_race();
    cur_time = mk(8'h58, 8'h59, 8'ha3, 8'h31, 8'h12, 8'h03);
    alm1_cfg = mk(8'hd7, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    do_tick();
    chk("R3 only alarm 0", status_byte, 8'h21);
    rd_begin();
    alm1_cfg = mk(8'hd8, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    do_tick();
    chk("R8 alarm 1 during read", status_byte, 8'h61);
    rd_end();
    chk("R8 late flag survives read", status_byte, 8'h41);
    rd_begin();
    rd_end();
    chk("R7 second read clears", status_byte, 8'h01);
  endtask

  task automatic t_no_enable();
    cur_time = '0;
    alm0_cfg = '0;
    alm1_cfg = mk(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    do_tick();
    do_tick();
    chk("R6 no enabled field never fires", status_byte, 8'h01);
  endtask

  task automatic t_latches();
    st_write(8'h06);
    chk("R10 06h without WEL ignored", status_byte, 8'h01);
    st_write(8'h02);
    chk("R9 02h sets WEL", status_byte, 8'h03);
    chk_all("R12 after 02h");
    st_write(8'h06);
    chk("R10 06h sets RWEL", status_byte, 8'h07);
    chk_all("R12 after 06h");
    st_write(8'h12);
    chk("R11 stray value ignored", status_byte, 8'h07);
    st_write(8'h04);
    chk("R11 04h ignored", status_byte, 8'h07);
    repeat (3) @(negedge clk);
    chk("R11 idle holds", status_byte, 8'h07);
    st_write(8'h02);
    chk("R9 02h clears RWEL", status_byte, 8'h03);
    st_write(8'h06);
    st_write(8'h00);
    chk("R9 00h clears both", status_byte, 8'h01);
    chk_all("R12 after 00h");
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_hw_bits();
    t_alarm_basic();
    t_read_clear();
    t_disabled_field();
    t_read_race();
    t_no_enable();
    t_latches();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule